// File: doc/BRIEF.md
# Strapped-Address Serial Management Register Slave

This block is a byte-wide slave on a two-wire serial management bus. It runs entirely in the system clock domain and oversamples the clock and data lines. Before the protocol logic uses them, both lines pass through a synchronizer and an edge detector. A master reaches a small internal register file through an address pointer. The first byte of every write transfer loads the pointer. Any further bytes in the same write go to the register the pointer selects. A read returns the register at the pointer, so a master can poll one register again and again without rewriting the pointer.

The seven-bit device address has a fixed upper part and two strapped low bits. A three-level strap input sets those low bits. It is sampled once, at the first START after reset, and then held until the next reset. The block also answers the alert response address while its alert request input is high. It replies with its own address and backs off at once if another device with a lower address wins the wired-AND arbitration. When it wins, it reports this with a one-cycle pulse so that the alert source can drop its request.

The data pin is open-drain style. `sda_oe` high pulls the line low, and `sda_oe` low releases it.

Top module: `smb_regif`

## Requirements
- R1: The device address is {01011, A1, A0}. The strap code `strap_lvl` maps 2'b00 (ground) to A1A0=00, 2'b01 (open) to 10, 2'b10 (supply) to 01, and 2'b11 to 10. A matching address byte is acknowledged. A non-matching one is not, and `sda_oe` stays low for that transfer.
- R2: A1A0 are latched at the first START after reset. Later changes on `strap_lvl` have no effect until the next reset.
- R3: A START (SDA falls while SCL is high) begins an address phase from any state, which also serves as a repeated START. A STOP (SDA rises while SCL is high) returns the block to idle with SDA released.
- R4: Bytes move MSB first, with an acknowledge on the ninth clock. The block changes `sda_oe` only while SCL is low.
- R5: The first data byte of a write loads the pointer. Every later byte of that write is stored in the register at the pointer, and the pointer is not incremented.
- R6: A read returns the register at the current pointer, including when no pointer write comes before it. If the master acknowledges, the same register is sent again. A NACK ends the read.
- R7: Addresses 00h up to RW_REGS-1 (00h to 07h by default) are read/write registers that reset to 00h.
- R8: Address 3Eh reads 41h and address 3Fh reads {4'h0, VERSION} (03h by default). Writes to these addresses are acknowledged and have no effect.
- R9: Reads from any other address return 00h. Writes to other addresses are acknowledged and have no effect.
- R10: A read to address 0001100 is acknowledged only while `alert_req` is high. The reply byte is {own address, 0}. After a full reply byte is sent without losing arbitration, `alert_done` pulses for one cycle.
- R11: During the alert reply, if the block releases SDA to send a 1 but samples a 0, it stops driving for the rest of the transfer and `alert_done` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_lvl | input | 2 | Three-level address strap code |
| alert_req | input | 1 | Alert pending, enables the alert response |
| alert_done | output | 1 | One-cycle pulse after winning the alert reply |

## Verification
The bench writes the pointer and then uses a repeated START to read, and also reads with no pointer write. A design that advanced the pointer, or that lost it across transfers, would return the neighbouring register. It writes to the fixed identity addresses, to an unmapped address and to one address past the read/write range, then reads them all back. A design that decoded past its range or let writes through would change the returned constants. It changes the strap after the first transfer and after a reset, which catches a design that samples the strap continuously. It also plays a competing alert responder with a lower address whose later 1 bits would be crushed to 0 if the block kept driving after losing arbitration.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RXADR, ST_ACK, ST_RXDAT, ST_TX, ST_MACK, ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {M_WR, M_RD, M_ARA} smb_mode_e;

  localparam logic [4:0] DEV_HI   = 5'b01011;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam logic [7:0] ID_ADDR  = 8'h3E;
  localparam logic [7:0] ID_VAL   = 8'h41;
  localparam logic [7:0] VER_ADDR = 8'h3F;

  // strap code: 00 ground, 01 open, 10 supply, 11 treated as open
  function automatic logic [1:0] strap_to_lo(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 2'b00;
      2'b10:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [6:0] dev_addr(input logic [1:0] lo);
    return {DEV_HI, lo};
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[i]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl[i]  = chain[STAGES-1];
    assign rise[i] = chain[STAGES-1] & ~prev;
    assign fall[i] = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int         RW_REGS = 8,
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  import smb_pkg::*;
  localparam int         IW     = (RW_REGS > 1) ? $clog2(RW_REGS) : 1;
  localparam logic [7:0] RW_LIM = 8'(RW_REGS);

  logic [7:0] regs [RW_REGS];
  logic       in_rw;
  assign in_rw = (addr < RW_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RW_REGS; i++) regs[i] <= 8'h00;
    end else if (wr_en && in_rw) begin
      regs[addr[IW-1:0]] <= wdata;
    end
  end

  always_comb begin
    if (in_rw)                 rdata = regs[addr[IW-1:0]];
    else if (addr == ID_ADDR)  rdata = ID_VAL;
    else if (addr == VER_ADDR) rdata = {4'h0, VERSION};
    else                       rdata = 8'h00;
  end
endmodule

// File: rtl/smb_regif.sv
module smb_regif #(
  parameter int         RW_REGS     = 8,
  parameter logic [3:0] VERSION     = 4'h3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] strap_lvl,
  input  logic       alert_req,
  output logic       alert_done
);
  import smb_pkg::*;

  logic [1:0] lvl, rise, fall;
  smb_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  // named bus events
  logic scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
  assign scl_s    = lvl[1];
  assign sda_s    = lvl[0];
  assign scl_rise = rise[1];
  assign scl_fall = fall[1];
  assign ev_start = fall[0] & scl_s;
  assign ev_stop  = rise[0] & scl_s;

  smb_state_e st;
  smb_mode_e  mode;
  logic [7:0] sh, tx, ptr;
  logic [3:0] cnt;
  logic       first_b, strap_done, mack, oe_r, done_r;
  logic [1:0] addr_lo;
  logic [6:0] own_addr;
  logic       byte_in, wr_en, bus_idle;
  logic [7:0] rdata;

  assign own_addr = dev_addr(addr_lo);
  assign byte_in  = scl_fall && (cnt == 4'd8);
  assign wr_en    = (st == ST_RXDAT) && byte_in && !first_b;
  assign bus_idle = (st == ST_IDLE);

  smb_regfile #(.RW_REGS(RW_REGS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr),
    .wdata(sh), .rdata(rdata)
  );

  // strap captured once per reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      addr_lo    <= 2'b00;
    end else if (!strap_done && ev_start) begin
      strap_done <= 1'b1;
      addr_lo    <= strap_to_lo(strap_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; mode <= M_WR; sh <= '0; tx <= '0; ptr <= '0;
      cnt <= '0; first_b <= 1'b0; mack <= 1'b0; oe_r <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (ev_start) begin
        st <= ST_RXADR; cnt <= '0; oe_r <= 1'b0;
      end else if (ev_stop) begin
        st <= ST_IDLE; oe_r <= 1'b0;
      end else begin
        case (st)
          ST_RXADR, ST_RXDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end
            if (byte_in) begin
              cnt <= '0;
              if (st == ST_RXDAT) begin
                if (first_b) ptr <= sh;
                first_b <= 1'b0;
                oe_r    <= 1'b1;
                st      <= ST_ACK;
              end else if (sh[7:1] == own_addr) begin
                mode    <= sh[0] ? M_RD : M_WR;
                first_b <= 1'b1;
                oe_r    <= 1'b1;
                st      <= ST_ACK;
              end else if (sh[7:1] == ARA_ADDR && sh[0] && alert_req) begin
                mode <= M_ARA;
                oe_r <= 1'b1;
                st   <= ST_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            case (mode)
              M_RD: begin
                tx <= rdata; oe_r <= ~rdata[7]; st <= ST_TX;
              end
              M_ARA: begin
                tx <= {own_addr, 1'b0}; oe_r <= ~own_addr[6]; st <= ST_TX;
              end
              default: begin
                oe_r <= 1'b0; st <= ST_RXDAT;
              end
            endcase
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
              if (mode == M_ARA && tx[7] && !sda_s) st <= ST_SKIP;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                cnt <= '0; oe_r <= 1'b0; st <= ST_MACK;
                if (mode == M_ARA) done_r <= 1'b1;
              end else begin
                tx   <= {tx[6:0], 1'b0};
                oe_r <= ~tx[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack && mode == M_RD) begin
                tx <= rdata; oe_r <= ~rdata[7]; st <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe     = oe_r;
  assign alert_done = done_r;

endmodule

// File: rtl/smb_regif_chk.sv
module smb_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       ev_stop,
  input logic       sda_oe,
  input logic       bus_idle,
  input logic       strap_done,
  input logic [1:0] addr_lo,
  input logic       alert_req,
  input logic       alert_done
);
  p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe);

  p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(addr_lo));

  p_done_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alert_done |-> alert_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alert_done |=> !alert_done);
endmodule

bind smb_regif smb_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .ev_stop(ev_stop),
  .sda_oe(sda_oe), .bus_idle(bus_idle), .strap_done(strap_done),
  .addr_lo(addr_lo), .alert_req(alert_req), .alert_done(alert_done)
);

// File: tb/smb_regif_tb.sv
`timescale 1ns/1ps
module smb_regif_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap_lvl = 2'b01;
  logic alert_req = 1'b0;
  logic sda_oe, alert_done;
  logic sda_line;
  int checks = 0, fails = 0, done_cnt = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_regif dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap_lvl(strap_lvl), .alert_req(alert_req),
    .alert_done(alert_done)
  );

  always @(posedge clk) if (alert_done) done_cnt <= done_cnt + 1;

  // {addr, write data, expected readback}
  localparam logic [23:0] VEC [9] = '{
    24'h00A5A5, 24'h015A5A, 24'h07FFFF, 24'h033C3C, 24'h028080,
    24'h3E1241, 24'h3F7703, 24'h50C300, 24'h081100
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic b_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic b_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic b_bit(input logic b, output logic line);
    sda_m = b; qw(); scl_m = 1'b1; qw(); line = sda_line; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic tx_byte(input logic [7:0] d, output logic ack);
    logic l;
    for (int i = 7; i >= 0; i--) b_bit(d[i], l);
    b_bit(1'b1, l);
    ack = ~l;
  endtask
  task automatic rx_byte(input logic mack, output logic [7:0] d);
    logic l;
    for (int i = 7; i >= 0; i--) begin b_bit(1'b1, l); d[i] = l; end
    b_bit(~mack, l);
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] a,
                        input logic [7:0] d, output logic ack);
    logic a1, a2, a3;
    b_start(); tx_byte({dev, 1'b0}, a1); tx_byte(a, a2); tx_byte(d, a3); b_stop();
    ack = a1 & a2 & a3;
  endtask
  task automatic rd_reg(input logic [6:0] dev, input logic [7:0] a, output logic [7:0] d);
    logic k;
    b_start(); tx_byte({dev, 1'b0}, k); tx_byte(a, k);
    b_start(); tx_byte({dev, 1'b1}, k); rx_byte(1'b0, d); b_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int dc;
    repeat (5) @(negedge clk);
    chk("R3 reset sda_oe", sda_oe, 0);
    chk("R10 reset alert_done", alert_done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7/R6: first transfer is a plain read at reset pointer 00h, strap open
    b_start(); tx_byte(8'h5D, ack); rx_byte(1'b0, d); b_stop();
    chk("R1 open strap ack", ack, 1);
    chk("R7 reset reg0", d, 8'h00);

    // table walk: R5 R8 R9 writes, then read back (R4 MSB-first patterns)
    foreach (VEC[i]) begin
      wr_reg(7'h2E, VEC[i][23:16], VEC[i][15:8], ack);
      chk("R8 R9 write acked", ack, 1);
    end
    foreach (VEC[i]) begin
      rd_reg(7'h2E, VEC[i][23:16], d);
      chk("R4 R5 R8 R9 readback", d, VEC[i][7:0]);
    end

    // R6: read without pointer write returns current pointer (last was 08h)
    rd_reg(7'h2E, 8'h02, d);
    b_start(); tx_byte(8'h5D, ack); rx_byte(1'b1, d); rx_byte(1'b0, d); b_stop();
    chk("R6 repeat read same reg", d, 8'h80);

    // R5: multiple write bytes land in the same register, pointer fixed
    b_start(); tx_byte(8'h5C, ack); tx_byte(8'h04, ack); tx_byte(8'hAA, ack);
    tx_byte(8'hBB, ack); b_stop();
    rd_reg(7'h2E, 8'h04, d);
    chk("R5 last byte kept", d, 8'hBB);
    rd_reg(7'h2E, 8'h05, d);
    chk("R5 no pointer increment", d, 8'h00);

    // R2: strap change after first START ignored
    strap_lvl = 2'b00;
    b_start(); tx_byte(8'h58, ack); b_stop();
    chk("R2 new strap address not acked", ack, 0);
    chk("R1 no drive after nack", sda_oe, 0);
    b_start(); tx_byte(8'h5C, ack); b_stop();
    chk("R2 latched address still acked", ack, 1);

    // R10: alert response gated by alert_req
    b_start(); tx_byte(8'h19, ack); b_stop();
    chk("R10 ara ignored without req", ack, 0);
    alert_req = 1'b1;
    dc = done_cnt;
    b_start(); tx_byte(8'h19, ack); rx_byte(1'b0, d); b_stop();
    chk("R10 ara acked", ack, 1);
    chk("R10 ara reply own address", d, 8'h5C);
    chk("R10 alert_done pulsed once", done_cnt - dc, 1);

    // R11: competitor 0000001 wins at bit 6, its later 1 must survive
    dc = done_cnt;
    b_start(); tx_byte(8'h19, ack);
    for (int i = 7; i >= 0; i--) begin
      logic l;
      b_bit(((8'h02 >> i) & 8'h01) != 0, l);
      d[i] = l;
    end
    b_bit(1'b1, ack); b_stop();
    chk("R11 line equals winner byte", d, 8'h02);
    chk("R11 no alert_done on loss", done_cnt - dc, 0);
    alert_req = 1'b0;

    // R2 R1 R7: reset re-samples strap (supply -> 0101101), registers cleared
    strap_lvl = 2'b10;
    @(negedge clk); rst_n = 1'b0; repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(7'h2D, 8'h00, d);
    chk("R7 reg0 cleared by reset", d, 8'h00);
    b_start(); tx_byte(8'h5A, ack); b_stop();
    chk("R1 R2 supply strap acked", ack, 1);
    b_start(); tx_byte(8'h5C, ack); b_stop();
    chk("R1 old address nacked", ack, 0);
    chk("R3 idle after stop", sda_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule